// File: doc/BRIEF.md
# Cascaded ADC Sample Clock Divider

This block derives the timing for an analog-to-digital converter from the peripheral bus clock. The bus clock is first halved, then optionally divided by a programmable prescaler, then divided by a programmable scaler. The result is a one-cycle converter clock enable, `conv_tick`, in the bus clock domain. A second output, `sample_tick`, marks every twelfth converter clock, since one conversion spans twelve converter clocks.

Both divider values come from one 32-bit clock control word, written through a simple write-only register port. Each field uses an (N+1) encoding, so a field of zero divides by one. A build-time parameter chooses between two variants. The two-stage variant has a 15-bit prescaler and a 10-bit scaler. The single-stage variant has a 16-bit scaler and no prescaler.

The chain runs only while `run_en` is high. A new divider value is taken up at the next terminal count of the stage it belongs to, so a period that is already under way is never cut short.

Top module: `adc_sample_clkgen`

## Requirements
- R1: While `rst_n` is low, both outputs are low. The asynchronous low reset clears both divider fields and all counters, and its release is synchronised to `clk`. After reset, with no write made, the chain runs with both fields at zero (D = 2).
- R2: Two-stage variant (TWO_STAGE=1). The control word is written at address 0x0C. The prescaler field P is in bits 31:17 and the scaler field S is in bits 9:0. Bits 16:10 are ignored. The converter period is D = 2·(P+1)·(S+1) bus clocks.
- R3: Single-stage variant (TWO_STAGE=0). The scaler field S is in bits 15:0 and bits 31:16 are ignored. The converter period is D = 2·(S+1) bus clocks.
- R4: Number the first cycle in which `run_en` is sampled high as cycle 0. `conv_tick` is high for exactly one cycle at each cycle n where (n+1) is a multiple of D, and it is low in every other cycle.
- R5: `sample_tick` is high only together with `conv_tick`, and only on every twelfth `conv_tick`. Its first pulse falls in cycle 12·D−1.
- R6: A write is ignored, and the period does not change, when its address is not 0x0C or when `wr_en` is low.
- R7: If the scaler field is changed while the chain runs, the converter period already under way finishes at its old length. Every later period has the new length.
- R8: While `run_en` is low, both outputs stay low and all counters return to zero. When `run_en` rises again, timing restarts as in R4.
- R9: `conv_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Engine enable; the divider chain runs while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| conv_tick | output | 1 | One-cycle converter clock enable |
| sample_tick | output | 1 | One-cycle strobe on every twelfth converter clock |

## Verification
Every output is a combinational decode of registered counters, so a result is due in the same cycle as the count that produces it. For a given configuration, the first `conv_tick` is due in cycle D−1 after enable and the first `sample_tick` in cycle 12·D−1. A field written in cycle k is held in the register from cycle k+1, and it changes the period only after the next terminal count. The bench raises the enable at a falling edge, counts cycles from that edge, samples 1 ns after each falling edge, and compares every cycle of a window with the expected pulse pattern computed from P, S and the write cycle.

// File: rtl/adc_clk_pkg.sv
package adc_clk_pkg;
  localparam int CTRL_W = 32;

  // Width of the scaler field for each variant.
  function automatic int scl_width(input bit two_stage);
    return two_stage ? 10 : 16;
  endfunction
endpackage

// File: rtl/adc_clkctl_reg.sv
module adc_clkctl_reg
  import adc_clk_pkg::*;
#(
  parameter bit              TWO_STAGE = 1'b1,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter int              PRE_W     = 15,
  parameter int              PRE_LSB   = 17,
  parameter int              SCL_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [PRE_W-1:0]  pre_field,
  output logic [SCL_W-1:0]  scl_field
);
  logic             hit;
  logic [SCL_W-1:0] scl_d, scl_q;
  logic [PRE_W-1:0] pre_d, pre_q;

  assign hit = wr_en && (wr_addr == CTRL_ADDR);

  generate
    if (TWO_STAGE) begin : g_two
      logic unused_gap;
      assign unused_gap = ^wr_data[PRE_LSB-1:SCL_W];
      always_comb begin
        pre_d = pre_q;
        if (hit) pre_d = wr_data[PRE_LSB +: PRE_W];
      end
    end else begin : g_one
      logic unused_high;
      assign unused_high = ^wr_data[CTRL_W-1:SCL_W];
      assign pre_d = '0;
    end
  endgenerate

  always_comb begin
    scl_d = scl_q;
    if (hit) scl_d = wr_data[SCL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      scl_q <= '0;
    end else begin
      pre_q <= pre_d;
      scl_q <= scl_d;
    end
  end

  assign pre_field = pre_q;
  assign scl_field = scl_q;
endmodule

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_tick,
  input  logic [W-1:0] field,
  output logic         out_tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q, lim_d;
  logic         term;

  assign term     = (cnt_q == lim_q);
  assign out_tick = run & in_tick & term;

  // The limit is reloaded only at terminal count or while idle.
  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (!run) begin
      cnt_d = '0;
      lim_d = field;
    end else if (in_tick) begin
      if (term) begin
        cnt_d = '0;
        lim_d = field;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/adc_sample_clkgen.sv
module adc_sample_clkgen
  import adc_clk_pkg::*;
#(
  parameter bit                TWO_STAGE       = 1'b1,
  parameter int                ADDR_W          = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR       = 8'h0C,
  parameter int                PRE_W           = 15,
  parameter int                PRE_LSB         = 17,
  parameter int                CONV_PER_SAMPLE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              conv_tick,
  output logic              sample_tick
);
  localparam int SCL_W = scl_width(TWO_STAGE);
  localparam int SMP_W = $clog2(CONV_PER_SAMPLE);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(CONV_PER_SAMPLE - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [PRE_W-1:0] pre_field;
  logic [SCL_W-1:0] scl_field;
  logic             half_q, half_d;
  logic             half_tick, pre_tick;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  adc_clkctl_reg #(
    .TWO_STAGE(TWO_STAGE), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .PRE_W(PRE_W), .PRE_LSB(PRE_LSB), .SCL_W(SCL_W)
  ) u_reg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pre_field(pre_field), .scl_field(scl_field)
  );

  // Fixed divide-by-two stage.
  always_comb half_d = run_en ? ~half_q : 1'b0;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) half_q <= 1'b0;
    else             half_q <= half_d;
  end
  assign half_tick = run_en & half_q;

  generate
    if (TWO_STAGE) begin : g_pre
      adc_tick_div #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_core_n), .run(run_en), .in_tick(half_tick),
        .field(pre_field), .out_tick(pre_tick)
      );
    end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = ^pre_field;
      assign pre_tick   = half_tick;
    end
  endgenerate

  adc_tick_div #(.W(SCL_W)) u_scl (
    .clk(clk), .rst_n(rst_core_n), .run(run_en), .in_tick(pre_tick),
    .field(scl_field), .out_tick(conv_tick)
  );

  adc_tick_div #(.W(SMP_W)) u_smp (
    .clk(clk), .rst_n(rst_core_n), .run(run_en), .in_tick(conv_tick),
    .field(SMP_LAST), .out_tick(sample_tick)
  );
endmodule

// File: rtl/adc_sample_clkgen_chk.sv
module adc_sample_clkgen_chk #(
  parameter int CPS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic conv_tick,
  input logic sample_tick
);
  localparam int CW = $clog2(CPS);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= '0;
    else if (!run_en)       seen_q <= '0;
    else if (sample_tick)   seen_q <= '0;
    else if (conv_tick)     seen_q <= seen_q + 1'b1;
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!conv_tick && !sample_tick)); // R8
  AST_SAMPLE_WITH_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> conv_tick); // R5
  AST_SAMPLE_TWELFTH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (seen_q == CW'(CPS - 1))); // R5
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |=> !conv_tick); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!conv_tick && !sample_tick)); // R1
endmodule

bind adc_sample_clkgen adc_sample_clkgen_chk #(.CPS(CONV_PER_SAMPLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en),
  .conv_tick(conv_tick), .sample_tick(sample_tick)
);

// File: tb/adc_sample_clkgen_test.sv
module adc_sample_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_ts = 1'b0, run_ss = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [31:0] wr_data = 32'h0;
  logic        conv_ts, smp_ts, conv_ss, smp_ss;
  int          nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  adc_sample_clkgen #(.TWO_STAGE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_ts), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_tick(conv_ts), .sample_tick(smp_ts));

  adc_sample_clkgen #(.TWO_STAGE(1'b0)) uut_ss (
    .clk(clk), .rst_n(rst_n), .run_en(run_ss), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_tick(conv_ss), .sample_tick(smp_ss));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Runs one variant from enable and compares every cycle with the expected pattern.
  task automatic measure(input bit ss, input int d, input int ncyc, input string req);
    int bad = 0, at = -1, act = 0, exp = 0;
    bit c, s, ec, es;
    @(negedge clk);
    if (ss) run_ss = 1'b1; else run_ts = 1'b1;
    #1;
    for (int n = 0; n < ncyc; n++) begin
      if (n > 0) begin @(negedge clk); #1; end
      c  = ss ? conv_ss : conv_ts;
      s  = ss ? smp_ss : smp_ts;
      ec = ((n + 1) % d) == 0;
      es = ((n + 1) % (12 * d)) == 0;
      if (c !== ec || s !== es) begin
        bad++;
        if (at < 0) begin at = n; act = {c, s}; exp = {ec, es}; end
      end
    end
    @(negedge clk);
    run_ss = 1'b0; run_ts = 1'b0;
    repeat (2) @(negedge clk);
    check(bad == 0, req, $sformatf("D=%0d first bad cycle %0d {conv,sample}", d, at), act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int bad;
    bit ec;
    // R1: outputs quiet during reset even with enable high
    run_ts = 1'b1; run_ss = 1'b1;
    repeat (3) @(negedge clk);
    check(conv_ts == 0 && smp_ts == 0 && conv_ss == 0 && smp_ss == 0, "R1", "outputs in reset", {conv_ts, smp_ts}, 0);
    run_ts = 1'b0; run_ss = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1/R4: cleared fields give D=2
    measure(1'b0, 2, 60, "R1");
    measure(1'b1, 2, 60, "R1");

    // R2/R4/R5: two-stage sweep, junk in bits 16:10
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++) begin
        wr(8'h0C, {15'(p), 7'h55, 10'(s)}, 1'b1);
        measure(1'b0, 2 * (p + 1) * (s + 1), 24 * (p + 1) * (s + 1) * 2 + 3, "R2");
      end
    wr(8'h0C, {15'd5, 7'h00, 10'd9}, 1'b1);
    measure(1'b0, 120, 12 * 120 + 10, "R5");

    // R3: single-stage sweep, junk in bits 31:16
    for (int s = 0; s < 8; s++) begin
      wr(8'h0C, {16'hA5A5, 16'(s)}, 1'b1);
      measure(1'b1, 2 * (s + 1), 24 * (s + 1) * 2 + 3, "R3");
    end

    // R6: other address and disabled strobe leave P=1,S=2
    wr(8'h0C, {15'd1, 7'h00, 10'd2}, 1'b1);
    wr(8'h08, {15'd3, 7'h00, 10'd0}, 1'b1);
    wr(8'h0C, {15'd0, 7'h00, 10'd5}, 1'b0);
    measure(1'b0, 12, 12 * 12 + 30, "R6");

    // R7: scaler change mid-period (S 3 -> 1, P=0), written in cycle 9
    wr(8'h0C, {15'd0, 7'h00, 10'd3}, 1'b1);
    bad = 0;
    @(negedge clk); run_ts = 1'b1; #1;
    for (int n = 0; n < 29; n++) begin
      if (n > 0) begin @(negedge clk); #1; end
      if (n == 10) wr_en = 1'b0;
      ec = (n == 7) || (n >= 15 && ((n - 15) % 4) == 0);
      if (conv_ts !== ec || smp_ts !== 1'b0) bad++;
      if (n == 9) begin wr_en = 1'b1; wr_addr = 8'h0C; wr_data = {15'd0, 7'h00, 10'd1}; end
    end
    check(bad == 0, "R7", "mismatching cycles after live write", bad, 0);

    // R8: disable mid-run silences outputs, then restart from zero (S=1 => D=4)
    repeat (10) @(negedge clk);
    run_ts = 1'b0;
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      #1; if (conv_ts !== 1'b0 || smp_ts !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8", "ticks while disabled", bad, 0);
    measure(1'b0, 4, 4 * 12 * 2 + 3, "R8");
    measure(1'b0, 4, 11, "R9");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule